// File: doc/BRIEF.md
# Mode-Gated Shift-Add Rotator Pair

This block computes two fixed-angle plane rotations side by side, each followed by its own scale-factor correction. Both are built only from shifts and adds, with no multiplier. Rotator A turns its vector by 3π/16 counter-clockwise. Rotator B turns its vector by π/16 clockwise. Together the two rotators feed one odd-index transform coefficient. Each rotator produces a primary output, which feeds the lower-frequency result, and a secondary output.

Every shift-add term passes through an AND gate. A mask chosen by the per-transaction level input drives that gate, so a disabled term presents a constant zero to its adder and does not toggle. There are three levels. Each higher level switches off more of the heavily shifted, low-weight terms, which trades accuracy for lower switching activity in the same datapath. Which terms are removed at each level is fixed at design time by constant mask parameters.

Top module: `prio_rotator_pair`

## Requirements
- R1: `out_valid` is low after reset. It rises exactly two clock edges after the edge that samples `in_valid` high, once per accepted transaction, and never at any other time.
- R2: The inputs are signed DW-bit integers. The outputs are signed integers with 8 fraction bits (real value = output / 256). Every term is exact, so nothing is rounded.
- R3: Normal level (`mode` = 2'b00), rotator A: primary = (1−2^-4)·ax − (2^-1+2^-3)·ay; secondary = (2^-1+2^-3)·ax + (1−2^-4)·ay; both are multiplied by the scale 2^-1−2^-4.
- R4: Normal level, rotator B: primary = (1+2^-1)·bx + 2^-2·by; secondary = −2^-2·bx + (1+2^-1)·by; both are multiplied by the scale 2^-2+2^-4.
- R5: Level 1 (`mode` = 2'b01): rotator A becomes primary = ax − 2^-1·ay, secondary = 2^-1·ax + ay, scale 2^-1. For rotator B, the primary is unchanged, the secondary becomes (1+2^-1)·by, and the scale becomes 2^-2.
- R6: Level 2 (`mode` = 2'b10, and 2'b11 behaves the same way): rotator A is as in level 1. For rotator B, the primary becomes (1+2^-1)·bx, the secondary is (1+2^-1)·by, and the scale is 2^-2.
- R7: The level is sampled together with the data of each transaction and travels with it. Back-to-back transactions with different levels each use their own level.
- R8: Between results, all four outputs hold the value of the last result.
- R9: Zero inputs give zero outputs at every level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Transaction strobe |
| mode | input | 2 | Precision level for this transaction |
| a_x | input | DW | Rotator A x operand |
| a_y | input | DW | Rotator A y operand |
| b_x | input | DW | Rotator B x operand |
| b_y | input | DW | Rotator B y operand |
| out_valid | output | 1 | Result strobe |
| a_p | output | DW+11 | Rotator A primary, scaled |
| a_q | output | DW+11 | Rotator A secondary, scaled |
| b_p | output | DW+11 | Rotator B primary, scaled |
| b_q | output | DW+11 | Rotator B secondary, scaled |

## Verification
Each transaction's four results appear two clock edges after the edge that samples its strobe. The level that applies is the one presented alongside that strobe. The bench drives inputs on the falling edge and shifts its expected values through a two-slot model. It compares the strobe and the data on the falling edge two cycles after the drive, so that every result is read at the cycle it becomes due. In cycles without a result, the bench compares the outputs against the last result to confirm they hold.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic [1:0] {
    LVL_NORM = 2'b00,
    LVL_ONE  = 2'b01,
    LVL_TWO  = 2'b10,
    LVL_TWOB = 2'b11
  } lvl_e;
  localparam int FRAC_BITS = 4;
endpackage

// File: rtl/gated_sum.sv
module gated_sum #(
  parameter int IW = 12,
  parameter int OW = 18,
  parameter int NT = 4,
  parameter logic [NT-1:0]   SRC  = '0,
  parameter logic [NT-1:0]   NEG  = '0,
  parameter logic [3*NT-1:0] SHF  = '0,
  parameter logic [NT-1:0]   MSK1 = '1,
  parameter logic [NT-1:0]   MSK2 = '1
) (
  input  prot_pkg::lvl_e        lvl,
  input  logic signed [IW-1:0]  op0,
  input  logic signed [IW-1:0]  op1,
  output logic signed [OW-1:0]  sum
);
  import prot_pkg::*;
  logic [NT-1:0] en;

  always_comb begin
    case (lvl)
      LVL_NORM: en = '1;
      LVL_ONE:  en = MSK1;
      default:  en = MSK2;
    endcase
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < NT; i++) begin
      logic signed [IW-1:0] sel;
      logic signed [IW-1:0] gated;
      logic signed [OW-1:0] term;
      sel   = SRC[i] ? op1 : op0;
      gated = sel & {IW{en[i]}};
      term  = {{(OW-IW){gated[IW-1]}}, gated};
      term  = (term <<< FRAC_BITS) >>> SHF[i*3 +: 3];
      sum   = NEG[i] ? (sum - term) : (sum + term);
    end
  end
endmodule

// File: rtl/fixed_rotator.sv
module fixed_rotator #(
  parameter int DW = 12,
  parameter int RW = 18,
  parameter int PT = 4,
  parameter logic [PT-1:0]   P_SRC = '0,
  parameter logic [PT-1:0]   P_NEG = '0,
  parameter logic [3*PT-1:0] P_SHF = '0,
  parameter logic [PT-1:0]   P_M1  = '1,
  parameter logic [PT-1:0]   P_M2  = '1,
  parameter int QT = 4,
  parameter logic [QT-1:0]   Q_SRC = '0,
  parameter logic [QT-1:0]   Q_NEG = '0,
  parameter logic [3*QT-1:0] Q_SHF = '0,
  parameter logic [QT-1:0]   Q_M1  = '1,
  parameter logic [QT-1:0]   Q_M2  = '1
) (
  input  prot_pkg::lvl_e        lvl,
  input  logic signed [DW-1:0]  vx,
  input  logic signed [DW-1:0]  vy,
  output logic signed [RW-1:0]  rp,
  output logic signed [RW-1:0]  rq
);
  gated_sum #(.IW(DW), .OW(RW), .NT(PT), .SRC(P_SRC), .NEG(P_NEG),
              .SHF(P_SHF), .MSK1(P_M1), .MSK2(P_M2))
    p_sum_i (.lvl(lvl), .op0(vx), .op1(vy), .sum(rp));

  gated_sum #(.IW(DW), .OW(RW), .NT(QT), .SRC(Q_SRC), .NEG(Q_NEG),
              .SHF(Q_SHF), .MSK1(Q_M1), .MSK2(Q_M2))
    q_sum_i (.lvl(lvl), .op0(vx), .op1(vy), .sum(rq));
endmodule

// File: rtl/prio_rotator_pair.sv
module prio_rotator_pair #(
  parameter int DW = 12,
  localparam int RW = DW + 6,
  localparam int OW = RW + 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           mode,
  input  logic signed [DW-1:0] a_x,
  input  logic signed [DW-1:0] a_y,
  input  logic signed [DW-1:0] b_x,
  input  logic signed [DW-1:0] b_y,
  output logic                 out_valid,
  output logic signed [OW-1:0] a_p,
  output logic signed [OW-1:0] a_q,
  output logic signed [OW-1:0] b_p,
  output logic signed [OW-1:0] b_q
);
  import prot_pkg::*;

  lvl_e in_lvl;
  assign in_lvl = lvl_e'(mode);

  logic signed [RW-1:0] ra_p, ra_q, rb_p, rb_q;
  logic signed [RW-1:0] s1_ap, s1_aq, s1_bp, s1_bq;
  lvl_e                 s1_lvl;
  logic                 s1_valid, s1_valid_nx, out_valid_nx;
  logic signed [OW-1:0] sa_p, sa_q, sb_p, sb_q;

  // 3pi/16 counter-clockwise: primary x - x/16 - y/2 - y/8
  fixed_rotator #(.DW(DW), .RW(RW),
    .PT(4), .P_SRC(4'b1100), .P_NEG(4'b1110),
    .P_SHF({3'd3, 3'd1, 3'd4, 3'd0}), .P_M1(4'b0101), .P_M2(4'b0101),
    .QT(4), .Q_SRC(4'b1100), .Q_NEG(4'b1000),
    .Q_SHF({3'd4, 3'd0, 3'd3, 3'd1}), .Q_M1(4'b0101), .Q_M2(4'b0101))
    rot_a_i (.lvl(in_lvl), .vx(a_x), .vy(a_y), .rp(ra_p), .rq(ra_q));

  // pi/16 clockwise: primary x + x/2 + y/4
  fixed_rotator #(.DW(DW), .RW(RW),
    .PT(3), .P_SRC(3'b100), .P_NEG(3'b000),
    .P_SHF({3'd2, 3'd1, 3'd0}), .P_M1(3'b111), .P_M2(3'b011),
    .QT(3), .Q_SRC(3'b110), .Q_NEG(3'b001),
    .Q_SHF({3'd1, 3'd0, 3'd2}), .Q_M1(3'b110), .Q_M2(3'b110))
    rot_b_i (.lvl(in_lvl), .vx(b_x), .vy(b_y), .rp(rb_p), .rq(rb_q));

  // scale stage, gated by the level carried with the data
  gated_sum #(.IW(RW), .OW(OW), .NT(2), .SRC(2'b00), .NEG(2'b10),
              .SHF({3'd4, 3'd1}), .MSK1(2'b01), .MSK2(2'b01))
    sc_ap_i (.lvl(s1_lvl), .op0(s1_ap), .op1(s1_ap), .sum(sa_p));
  gated_sum #(.IW(RW), .OW(OW), .NT(2), .SRC(2'b00), .NEG(2'b10),
              .SHF({3'd4, 3'd1}), .MSK1(2'b01), .MSK2(2'b01))
    sc_aq_i (.lvl(s1_lvl), .op0(s1_aq), .op1(s1_aq), .sum(sa_q));
  gated_sum #(.IW(RW), .OW(OW), .NT(2), .SRC(2'b00), .NEG(2'b00),
              .SHF({3'd4, 3'd2}), .MSK1(2'b01), .MSK2(2'b01))
    sc_bp_i (.lvl(s1_lvl), .op0(s1_bp), .op1(s1_bp), .sum(sb_p));
  gated_sum #(.IW(RW), .OW(OW), .NT(2), .SRC(2'b00), .NEG(2'b00),
              .SHF({3'd4, 3'd2}), .MSK1(2'b01), .MSK2(2'b01))
    sc_bq_i (.lvl(s1_lvl), .op0(s1_bq), .op1(s1_bq), .sum(sb_q));

  always_comb begin
    s1_valid_nx  = in_valid;
    out_valid_nx = s1_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      s1_valid  <= s1_valid_nx;
      out_valid <= out_valid_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_ap  <= ra_p;
      s1_aq  <= ra_q;
      s1_bp  <= rb_p;
      s1_bq  <= rb_q;
      s1_lvl <= in_lvl;
    end
    if (s1_valid) begin
      a_p <= sa_p;
      a_q <= sa_q;
      b_p <= sb_p;
      b_q <= sb_q;
    end
  end
endmodule

// File: rtl/prio_rotator_pair_chk.sv
module prio_rotator_pair_chk #(
  parameter int DW = 12,
  localparam int OW = DW + 11
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 s1_valid,
  input logic signed [DW-1:0] a_x,
  input logic signed [DW-1:0] a_y,
  input logic signed [DW-1:0] b_x,
  input logic signed [DW-1:0] b_y,
  input logic                 out_valid,
  input logic signed [OW-1:0] a_p,
  input logic signed [OW-1:0] a_q,
  input logic signed [OW-1:0] b_p,
  input logic signed [OW-1:0] b_q
);
  a_r1_result_due: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(s1_valid));

  a_r2_known_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown({a_p, a_q, b_p, b_q}));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !s1_valid) |=> ($stable(a_p) && $stable(a_q) && $stable(b_p) && $stable(b_q)));

  a_r9_zero_in: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a_x == '0 && a_y == '0 && b_x == '0 && b_y == '0)
      |-> ##2 (a_p == '0 && a_q == '0 && b_p == '0 && b_q == '0));
endmodule

bind prio_rotator_pair prio_rotator_pair_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .s1_valid(s1_valid),
  .a_x(a_x), .a_y(a_y), .b_x(b_x), .b_y(b_y), .out_valid(out_valid),
  .a_p(a_p), .a_q(a_q), .b_p(b_p), .b_q(b_q));

// File: tb/prio_rotator_pair_tb.sv
module prio_rotator_pair_tb_top;
  localparam int DW = 12;
  localparam int OW = DW + 11;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [1:0] mode;
  logic signed [DW-1:0] a_x, a_y, b_x, b_y;
  logic out_valid;
  logic signed [OW-1:0] a_p, a_q, b_p, b_q;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_rotator_pair #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .a_x(a_x), .a_y(a_y), .b_x(b_x), .b_y(b_y), .out_valid(out_valid),
    .a_p(a_p), .a_q(a_q), .b_p(b_p), .b_q(b_q));

  // weights in sixteenths: sel 0=A primary,1=A secondary,2=B primary,3=B secondary
  function automatic longint model(int sel, int m, longint x, longint y);
    longint wx, wy, sc;
    bit n = (m == 0);
    case (sel)
      0: begin wx = n ? 15 : 16;  wy = n ? -10 : -8; end
      1: begin wx = n ? 10 : 8;   wy = n ? 15 : 16;  end
      2: begin wx = 24;           wy = (m >= 2) ? 0 : 4; end
      default: begin wx = n ? -4 : 0; wy = 24; end
    endcase
    if (sel < 2) sc = n ? 7 : 8;
    else         sc = n ? 5 : 4;
    return sc * (wx * x + wy * y);
  endfunction

  typedef struct { bit v; int m; longint e[4]; } slot_t;
  slot_t d1, d2, cur;
  longint last[4];
  bit have_last = 0;

  function automatic string rtag(int sel, int m);
    if (m == 0) return (sel < 2) ? "R3" : "R4";
    if (m == 1) return "R5";
    return "R6";
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, int m, int ax, int ay, int bx, int by);
    longint got[4];
    @(negedge clk);
    d2 = d1;
    d1 = cur;
    got[0] = longint'(a_p); got[1] = longint'(a_q);
    got[2] = longint'(b_p); got[3] = longint'(b_q);
    check(out_valid == d2.v, "R1 out_valid", longint'(out_valid), longint'(d2.v));
    if (d2.v) begin
      for (int k = 0; k < 4; k++)
        check(got[k] == d2.e[k], {rtag(k, d2.m), " R2 R7 data"}, got[k], d2.e[k]);
      last = d2.e;
      have_last = 1;
    end else if (have_last) begin
      for (int k = 0; k < 4; k++)
        check(got[k] == last[k], "R8 hold", got[k], last[k]);
    end
    in_valid = v;
    mode = 2'(m);
    a_x = DW'(ax); a_y = DW'(ay); b_x = DW'(bx); b_y = DW'(by);
    cur.v = v;
    cur.m = m;
    cur.e[0] = model(0, m, ax, ay);
    cur.e[1] = model(1, m, ax, ay);
    cur.e[2] = model(2, m, bx, by);
    cur.e[3] = model(3, m, bx, by);
  endtask

  function automatic int rnd();
    return int'($urandom_range(4095)) - 2048;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    d1 = '{v: 0, m: 0, e: '{0, 0, 0, 0}};
    d2 = d1;
    cur = d1;
    rst_n = 1'b0;
    in_valid = 1'b0;
    mode = 2'b00;
    a_x = '0; a_y = '0; b_x = '0; b_y = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    // R3 R4 R5 R6: fixed vectors in every level, including 2'b11
    for (int m = 0; m < 4; m++) begin
      step(1, m, 100, 37, -55, 200);
      step(0, m, 0, 0, 0, 0);
      step(1, m, 2047, -2048, -2048, 2047);
      step(1, m, -2048, -2048, 2047, 2047);
    end
    // R9: zero operands at each level
    for (int m = 0; m < 4; m++) step(1, m, 0, 0, 0, 0);
    // R7: level changes every cycle, back to back
    for (int i = 0; i < 200; i++) step(1, i % 4, rnd(), rnd(), rnd(), rnd());
    // mixed strobes, R8 holds in gaps
    for (int i = 0; i < 300; i++)
      step(($urandom_range(2) != 0), int'($urandom_range(3)), rnd(), rnd(), rnd(), rnd());
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule